// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

The controller owns a row of general-purpose pins grouped into banks of 32. Software reaches it through a plain register bus: one byte address, a write enable, a write data word and a read data word that answers in the same cycle. Each bank has eight registers:

- a direction word;
- a pair of write-one set and write-one clear ports that move an output latch;
- a level word showing the synchronized pin inputs;
- rising and falling edge enables;
- a per-pin edge gate;
- a sticky edge status that is cleared by writing ones.

Every pin input passes through a two-flop synchronizer. An edge is detected by comparing the synchronized sample with the one taken a cycle earlier. A single interrupt line summarises the status bits of all banks, so a handler can poll the banks, acknowledge the bits it has serviced and return.

A parameter mask flips the direction polarity of selected pins. For those pins, a direction bit of 0 enables the output driver.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: Bank n decodes at byte base ((n/3)<<8)+((n%3)<<2). Register offsets from that base are 0x00 level, 0x0C direction, 0x18 set, 0x24 clear, 0x30 rising enable, 0x3C falling enable, 0x48 edge status and 0x9C edge gate. Pin p is bit p%32 of bank p/32 and is bit p of the pin buses.
- R2: Writing a word to the set offset drives each pin whose bit is 1 high, and writing to the clear offset drives each such pin low. Zero bits leave the latch unchanged. Reads of either offset return the latch, and pin_out_o carries the latch.
- R3: The output latch changes only on a bus write.
- R4: The direction word reads back as written. pin_oe_o for pin p is its direction bit XOR bit p of DIR_INV, so for non-inverted pins a 1 means output. The output enables change only on a bus write.
- R5: The level offset returns the pin inputs after two flops, whatever each pin's direction. An input change presented before clock edge k is readable after edge k+1. Writes to the level offset have no effect.
- R6: A status bit becomes 1 on a rising input edge with its rising enable set, or on a falling edge with its falling enable set. A change presented before edge k is first readable after edge k+2.
- R7: Writing 1 to a status bit clears it, and a 0 bit leaves it unchanged. All ones clears the bank. A status bit with no write to it stays set. When a new edge lands in the same cycle as the clear of that bit, the bit stays set.
- R8: A status bit whose edge gate bit is 0 is never set by an edge.
- R9: irq_o is high exactly when some status bit in some bank is set.
- R10: Reset clears direction, latch, both enables, status and edge gate. After reset, pin_oe_o equals DIR_INV and irq_o is low.
- R11: Reads of any address that is not a register offset of an existing bank, including misaligned addresses, return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address of the register |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | PIN_W | Write data |
| rdata_o | output | PIN_W | Read data for addr_i, same cycle |
| pin_in_i | input | NUM_BANKS*PIN_W | Asynchronous pin inputs |
| pin_out_o | output | NUM_BANKS*PIN_W | Output latch per pin |
| pin_oe_o | output | NUM_BANKS*PIN_W | Output driver enable per pin |
| irq_o | output | 1 | Any edge status set |

## Verification
The bench targets an edge that arrives in the same cycle as a clear of its own status bit. A design that lets the clear win would silently lose that event and show the bit as 0.

It measures level and status latency edge by edge. A design with one synchronizer flop too few or too many would report the change a cycle early or late.

It raises edges with the gate closed, and with only the opposite-direction enable set. A design that ignores the gate or mixes up the enables would set a status bit and the interrupt.

It places pins in the last bank at bit 31 and writes the level and unmapped offsets. A wrong interleave, a writable level word or a non-zero default read would then show up as a wrong word in another bank.

// File: rtl/edge_gpio_pkg.sv
package edge_gpio_pkg;
  localparam int unsigned NKIND = 8;

  typedef enum logic [2:0] {
    K_LEVEL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL, K_STAT, K_GATE
  } reg_kind_e;

  function automatic int unsigned kind_off(reg_kind_e k);
    case (k)
      K_LEVEL: return 32'h00;
      K_DIR:   return 32'h0C;
      K_SET:   return 32'h18;
      K_CLR:   return 32'h24;
      K_RISE:  return 32'h30;
      K_FALL:  return 32'h3C;
      K_STAT:  return 32'h48;
      K_GATE:  return 32'h9C;
      default: return 32'h00;
    endcase
  endfunction

  // three banks share a 256-byte block, 4 bytes apart
  function automatic int unsigned bank_base(int unsigned n);
    return ((n / 3) << 8) + ((n % 3) << 2);
  endfunction
endpackage

// File: rtl/edge_gpio_sync.sv
module edge_gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/edge_gpio_edge.sv
module edge_gpio_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] gate_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign evt_o = ((lvl_i & ~prev_q & rise_en_i) |
                  (~lvl_i & prev_q & fall_en_i)) & gate_i;
endmodule

// File: rtl/edge_gpio_bank.sv
module edge_gpio_bank
  import edge_gpio_pkg::*;
#(
  parameter int unsigned BANK_IDX = 0,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned PIN_W    = 32,
  parameter logic [PIN_W-1:0] INV_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [PIN_W-1:0]  wdata_i,
  input  logic [PIN_W-1:0]  pin_in_i,
  output logic [PIN_W-1:0]  rdata_o,
  output logic [PIN_W-1:0]  pin_out_o,
  output logic [PIN_W-1:0]  pin_oe_o,
  output logic [PIN_W-1:0]  status_o,
  output logic [PIN_W-1:0]  gate_o
);
  localparam int unsigned BASE = bank_base(BANK_IDX);

  logic [NKIND-1:0] hit;
  logic [PIN_W-1:0] rd_word [NKIND];

  for (genvar k = 0; k < NKIND; k++) begin : g_dec
    localparam logic [ADDR_W-1:0] KADDR =
      ADDR_W'(BASE + kind_off(reg_kind_e'(k)));
    assign hit[k] = (addr_i == KADDR);
  end

  logic [PIN_W-1:0] dir_q, out_q, rise_q, fall_q, stat_q, gate_q;
  logic [PIN_W-1:0] lvl, evt, clr_bits;

  edge_gpio_sync #(.W(PIN_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (lvl)
  );

  edge_gpio_edge #(.W(PIN_W)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl),
    .rise_en_i(rise_q),
    .fall_en_i(fall_q),
    .gate_i   (gate_q),
    .evt_o    (evt)
  );

  assign clr_bits = (wr_en_i && hit[K_STAT]) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      gate_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en_i && hit[K_DIR])  dir_q  <= wdata_i;
      if (wr_en_i && hit[K_RISE]) rise_q <= wdata_i;
      if (wr_en_i && hit[K_FALL]) fall_q <= wdata_i;
      if (wr_en_i && hit[K_GATE]) gate_q <= wdata_i;
      if (wr_en_i && hit[K_SET])  out_q  <= out_q | wdata_i;
      if (wr_en_i && hit[K_CLR])  out_q  <= out_q & ~wdata_i;
      // new edge wins over a coincident clear
      stat_q <= (stat_q & ~clr_bits) | evt;
    end
  end

  assign rd_word[K_LEVEL] = lvl;
  assign rd_word[K_DIR]   = dir_q;
  assign rd_word[K_SET]   = out_q;
  assign rd_word[K_CLR]   = out_q;
  assign rd_word[K_RISE]  = rise_q;
  assign rd_word[K_FALL]  = fall_q;
  assign rd_word[K_STAT]  = stat_q;
  assign rd_word[K_GATE]  = gate_q;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NKIND; k++)
      if (hit[k]) rdata_o = rdata_o | rd_word[k];
  end

  assign pin_out_o = out_q;
  assign pin_oe_o  = dir_q ^ INV_MASK;
  assign status_o  = stat_q;
  assign gate_o    = gate_q;
endmodule

// File: rtl/edge_gpio_ctrl.sv
module edge_gpio_ctrl
  import edge_gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned PIN_W     = 32,
  parameter int unsigned ADDR_W    = 10,
  parameter logic [NUM_BANKS*PIN_W-1:0] DIR_INV = 96'h0F00_0000_0000_0000_0000_0000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_en_i,
  input  logic [PIN_W-1:0]           wdata_i,
  output logic [PIN_W-1:0]           rdata_o,
  input  logic [NUM_BANKS*PIN_W-1:0] pin_in_i,
  output logic [NUM_BANKS*PIN_W-1:0] pin_out_o,
  output logic [NUM_BANKS*PIN_W-1:0] pin_oe_o,
  output logic                       irq_o
);
  localparam int unsigned NPINS = NUM_BANKS * PIN_W;

  logic [PIN_W-1:0] bank_rdata [NUM_BANKS];
  logic [NPINS-1:0] status_all;
  logic [NPINS-1:0] gate_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    edge_gpio_bank #(
      .BANK_IDX(b),
      .ADDR_W  (ADDR_W),
      .PIN_W   (PIN_W),
      .INV_MASK(DIR_INV[b*PIN_W +: PIN_W])
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .addr_i   (addr_i),
      .wr_en_i  (wr_en_i),
      .wdata_i  (wdata_i),
      .pin_in_i (pin_in_i[b*PIN_W +: PIN_W]),
      .rdata_o  (bank_rdata[b]),
      .pin_out_o(pin_out_o[b*PIN_W +: PIN_W]),
      .pin_oe_o (pin_oe_o[b*PIN_W +: PIN_W]),
      .status_o (status_all[b*PIN_W +: PIN_W]),
      .gate_o   (gate_all[b*PIN_W +: PIN_W])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) rdata_o = rdata_o | bank_rdata[b];
  end

  assign irq_o = |status_all;
endmodule

// File: rtl/edge_gpio_chk.sv
module edge_gpio_chk
  import edge_gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned PIN_W     = 32,
  parameter int unsigned ADDR_W    = 10
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-1:0]          addr_i,
  input logic                       wr_en_i,
  input logic [PIN_W-1:0]           rdata_o,
  input logic [NUM_BANKS*PIN_W-1:0] pin_out_o,
  input logic [NUM_BANKS*PIN_W-1:0] pin_oe_o,
  input logic                       irq_o,
  input logic [NUM_BANKS*PIN_W-1:0] status_all,
  input logic [NUM_BANKS*PIN_W-1:0] gate_all
);
  logic mapped;

  always_comb begin
    mapped = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++)
      for (int k = 0; k < NKIND; k++)
        if (addr_i == ADDR_W'(bank_base(b) + kind_off(reg_kind_e'(k))))
          mapped = 1'b1;
  end

  // R3
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pin_out_o));

  // R4
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pin_oe_o));

  // R7
  status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (($past(status_all) & ~status_all) == '0));

  // R8
  gate_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_all & ~$past(status_all) & ~$past(gate_all)) == '0));

  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_en_i) |=> irq_o);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (rdata_o == '0));
endmodule

bind edge_gpio_ctrl edge_gpio_chk #(
  .NUM_BANKS(NUM_BANKS),
  .PIN_W    (PIN_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .rdata_o   (rdata_o),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o),
  .irq_o     (irq_o),
  .status_all(status_all),
  .gate_all  (gate_all)
);

// File: tb/edge_gpio_ctrl_bench.sv
`timescale 1ns/1ps
module edge_gpio_ctrl_bench;
  localparam logic [95:0] INV = 96'h0F00_0000_0000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [95:0] pin_in = '0;
  logic [95:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  edge_gpio_ctrl u_edge_gpio_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .addr_i   (addr),
    .wr_en_i  (we),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .pin_in_i (pin_in),
    .pin_out_o(pin_out),
    .pin_oe_o (pin_oe),
    .irq_o    (irq)
  );

  // {write address, write data, expected readback at write address}
  localparam logic [73:0] VEC [12] = '{
    {10'h00C, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {10'h010, 32'h1234_5678, 32'h1234_5678},
    {10'h014, 32'hFFFF_0000, 32'hFFFF_0000},
    {10'h030, 32'h0000_00FF, 32'h0000_00FF},
    {10'h040, 32'hFF00_0000, 32'hFF00_0000},
    {10'h0A4, 32'h8000_0001, 32'h8000_0001},
    {10'h018, 32'h0000_00F0, 32'h0000_00F0},
    {10'h018, 32'h0000_000F, 32'h0000_00FF},
    {10'h024, 32'h0000_0030, 32'h0000_00CF},
    {10'h01C, 32'h8000_0000, 32'h8000_0000},
    {10'h028, 32'h0000_0000, 32'h8000_0000},
    {10'h000, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R10 reset state
    rd(10'h00C, v); chk("R10 dir b0", v, 32'h0);
    rd(10'h09C, v); chk("R10 gate b0", v, 32'h0);
    rd(10'h050, v); chk("R10 status b2", v, 32'h0);
    rd(10'h018, v); chk("R10 latch b0", v, 32'h0);
    chk("R10 irq", {31'h0, irq}, 32'h0);
    chk("R10 oe b2", pin_oe[95:64], INV[95:64]);
    chk("R10 oe b0", pin_oe[31:0], 32'h0);

    // R1/R2/R4/R5 register vectors
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][73:64], VEC[i][63:32]);
      rd(VEC[i][73:64], v);
      chk($sformatf("R1/R2/R4/R5 vector %0d", i), v, VEC[i][31:0]);
    end

    chk("R2 pin_out b0", pin_out[31:0], 32'h0000_00CF);
    chk("R2 pin_out b1", pin_out[63:32], 32'h8000_0000);
    chk("R5 level write no effect on pin_out", pin_out[31:0], 32'h0000_00CF);
    chk("R4 oe b0", pin_oe[31:0], 32'hA5A5_0F0F);
    chk("R4 oe b1", pin_oe[63:32], 32'h1234_5678);
    chk("R4 oe b2 inverted", pin_oe[95:64], 32'hF0FF_0000);

    // R11 unmapped reads
    rd(10'h054, v); chk("R11 0x054", v, 32'h0);
    rd(10'h0A8, v); chk("R11 0x0A8", v, 32'h0);
    rd(10'h100, v); chk("R11 0x100", v, 32'h0);
    rd(10'h00E, v); chk("R11 misaligned", v, 32'h0);

    // edge setup on bank 0, gate still closed
    wr(10'h030, 32'h0000_0005);
    wr(10'h03C, 32'h0000_0006);
    pin_in[0] = 1'b1;
    idle(4);
    rd(10'h048, v); chk("R8 gate closed", v, 32'h0);
    chk("R8 irq gate closed", {31'h0, irq}, 32'h0);
    pin_in[0] = 1'b0;
    idle(4);
    wr(10'h09C, 32'hFFFF_FFFF);
    rd(10'h09C, v); chk("R1 gate b0 readback", v, 32'hFFFF_FFFF);

    // precise latency: input changes before edge k
    pin_in[0] = 1'b1;
    @(negedge clk);
    rd(10'h000, v); chk("R5 level after k", v, 32'h0);
    @(negedge clk);
    rd(10'h000, v); chk("R5 level after k+1", v, 32'h1);
    rd(10'h048, v); chk("R6 status after k+1", v, 32'h0);
    @(negedge clk);
    rd(10'h048, v); chk("R6 status after k+2", v, 32'h1);
    chk("R9 irq set", {31'h0, irq}, 32'h1);

    // falling enable only on bit 1
    pin_in[1] = 1'b1;
    idle(4);
    rd(10'h048, v); chk("R6 rise ignored w/o rise enable", v, 32'h1);
    pin_in[1] = 1'b0;
    idle(4);
    rd(10'h048, v); chk("R6 fall detected", v, 32'h3);
    wr(10'h048, 32'h0000_0001);
    rd(10'h048, v); chk("R7 w1c bit0", v, 32'h2);
    wr(10'h048, 32'h0000_0000);
    rd(10'h048, v); chk("R7 zero write", v, 32'h2);

    // bit 2: edge coincident with its clear
    pin_in[2] = 1'b1;
    idle(4);
    rd(10'h048, v); chk("R6 rise bit2", v, 32'h6);
    pin_in[2] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    addr = 10'h048; wdata = 32'h0000_0004; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    rd(10'h048, v); chk("R7 edge beats clear", v, 32'h6);
    wr(10'h048, 32'hFFFF_FFFF);
    rd(10'h048, v); chk("R7 all ones clear", v, 32'h0);
    chk("R9 irq low", {31'h0, irq}, 32'h0);

    // gate bit0 closed: pin0 fall then rise
    wr(10'h09C, 32'hFFFF_FFFE);
    pin_in[0] = 1'b0;
    idle(4);
    pin_in[0] = 1'b1;
    idle(4);
    rd(10'h048, v); chk("R8 gated bit0", v, 32'h0);

    // level readback ignores direction (bank 1 partly output)
    pin_in[63:32] = 32'hDEAD_BEEF;
    idle(3);
    rd(10'h004, v); chk("R5 level b1", v, 32'hDEAD_BEEF);

    // bank 2: pin 95 gated in, pin 65 gated out
    wr(10'h038, 32'hFFFF_FFFF);
    pin_in[95] = 1'b1;
    pin_in[65] = 1'b1;
    idle(4);
    rd(10'h050, v); chk("R1 status b2 pin95", v, 32'h8000_0000);
    rd(10'h048, v); chk("R1 status b0 untouched", v, 32'h0);
    chk("R9 irq from b2", {31'h0, irq}, 32'h1);
    wr(10'h050, 32'h8000_0000);
    chk("R9 irq cleared", {31'h0, irq}, 32'h0);

    // reset again
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    rd(10'h010, v); chk("R10 dir b1 after reset", v, 32'h0);
    rd(10'h0A4, v); chk("R10 gate b2 after reset", v, 32'h0);
    chk("R10 pin_out after reset", pin_out[63:32], 32'h0);
    chk("R10 oe b2 after reset", pin_oe[95:64], INV[95:64]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule